// File: doc/BRIEF.md
# Boot Source Selector and Flash Address Decoder

This block chooses the flash device the processor boots from and places that device's code in the 1 MB boot window at the top of the 32-bit address space. After power-on reset the boot source comes from a board jumper. With the jumper fitted, the socketed 8-bit flash boots the board. With it removed, the boot source is one of the on-board 16-bit NOR banks. The NOR bank that boots is the designated primary bank unless a watchdog expiry has requested a fall-back. In that case the bank after the primary is used.

A fall-back request is recorded in a sticky flag. A strap enables or disables it. Software clears it by writing 1. A new boot source, whether from the jumper, the primary designation or the fall-back flag, is only loaded when a board reset pulse arrives. The boot source therefore never changes while code is running from it.

Every processor request marked valid is decoded into one registered chip select and a byte offset inside the selected device. An address that falls in no region raises a one-cycle decode error. Requests flow in on a plain valid qualifier. There is no ready signal: the decoder accepts one request on every clock and applies no back-pressure. Each request gives exactly one result one cycle later.

Top module: `boot_select`

## Requirements
- R1: During the synchronous active-low reset `rst_n`, the boot source copies `jumper_fit` (1 = socket). The active bank, the primary bank and the fall-back flag are cleared, and all decode outputs are 0.
- R2: `boot_status` has bit 5 = 1 when booting from the socket, bit 1 = the fall-back flag and bit 0 = the active NOR bank. All other bits read 0.
- R3: A valid request in 0xFC80_0000–0xFC87_FFFF selects the socket, with offset = address bits 18:0, whatever the boot source.
- R4: A valid request in 0xE000_0000–0xE1FF_FFFF selects NOR bank `addr[24]` (`cs_nor` bit 0 = bank 0, bit 1 = bank 1), with offset = address bits 23:0.
- R5: A valid request in 0xFFF0_0000–0xFFFF_FFFF, while booting from the socket, selects the socket with offset = address bits 18:0. The 512 KB device therefore appears twice in the window.
- R6: The same window, while booting from NOR, selects the active bank with offset = address bits 19:0, which is the bottom 1 MB of that bank.
- R7: Decode results appear in the cycle after the valid request. At most one of the three selects and `dec_err` is high. An address outside all regions gives `dec_err` for one cycle and no select. A cycle without a valid request gives all zeros.
- R8: A `wdog_exp` pulse sets the fall-back flag only while `redir_en` is 1. With `redir_en` at 0 it has no effect.
- R9: `clr_flag` clears the flag. If an enabled expiry arrives in the same cycle, the expiry wins.
- R10: `sel_wr` loads `sel_bank` as the primary bank. On `brd_rst` the active bank becomes (primary + flag) mod 2, using the values held before that edge. At no other time does the active bank change.
- R11: A change of `jumper_fit` alters the boot source only at `brd_rst` or power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| jumper_fit | input | 1 | 1 = boot jumper fitted (socket boot) |
| redir_en | input | 1 | Strap, 1 = fall-back circuitry enabled |
| wdog_exp | input | 1 | Watchdog expiry pulse |
| brd_rst | input | 1 | Board reset pulse that loads the boot choice |
| sel_wr | input | 1 | Write strobe for the primary bank |
| sel_bank | input | 1 | Primary bank value |
| clr_flag | input | 1 | Write-1 clear of the fall-back flag |
| req_valid | input | 1 | Address request valid |
| req_addr | input | 32 | Processor byte address |
| cs_sock | output | 1 | Socketed flash select |
| cs_nor | output | 2 | NOR bank selects, one-hot |
| dev_off | output | 24 | Byte offset inside the selected device |
| dec_err | output | 1 | One-cycle decode error |
| boot_status | output | 8 | Boot status byte |

## Verification
The hardest case to reach is a boot window access that lands in NOR bank 1. It needs three things in order: an enabled watchdog expiry, the jumper removed, and then a board reset pulse. After that, the next boot window request must land in bank 1 and not in the socket. The stimulus walks through that order. It also pairs `sel_wr` and `clr_flag` with board resets, so that both the primary-plus-flag sum and the plain-primary case get latched. A long random stream then mixes requests with pulses on every control input. A behavioural model follows all of it and is compared on every clock.

// File: rtl/boot_select_pkg.sv
package boot_select_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned STATUS_W    = 8;
  localparam int unsigned ST_SOCK_BIT = 5;
  localparam int unsigned ST_FLAG_BIT = 1;
  localparam int unsigned ST_BANK_BIT = 0;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_SOCK = 2'd1,
    RG_NOR  = 2'd2,
    RG_BOOT = 2'd3
  } region_e;
endpackage

// File: rtl/boot_sel_state.sv
module boot_sel_state #(
  parameter int unsigned BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jumper_fit,
  input  logic              redir_en,
  input  logic              wdog_exp,
  input  logic              brd_rst,
  input  logic              sel_wr,
  input  logic [BANK_W-1:0] sel_bank,
  input  logic              clr_flag,
  output logic              boot_sock,
  output logic [BANK_W-1:0] boot_bank,
  output logic              redir_flag
);
  logic [BANK_W-1:0] prim_bank;
  logic [BANK_W-1:0] next_bank;
  logic              expire_ok;

  assign expire_ok = wdog_exp & redir_en;
  assign next_bank = prim_bank + BANK_W'(redir_flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_sock  <= jumper_fit;
      boot_bank  <= '0;
      prim_bank  <= '0;
      redir_flag <= 1'b0;
    end else begin
      if (brd_rst) begin
        boot_sock <= jumper_fit;
        boot_bank <= next_bank;
      end
      if (sel_wr) prim_bank <= sel_bank;
      if (expire_ok)     redir_flag <= 1'b1;
      else if (clr_flag) redir_flag <= 1'b0;
    end
  end

  a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_flag) |-> $past(wdog_exp && redir_en));
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !wdog_exp) |=> !redir_flag);
  a_r10_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(boot_bank) && $past(rst_n)) |-> $past(brd_rst));
  a_r11_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(boot_sock) && $past(rst_n)) |-> $past(brd_rst));
endmodule

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
  import boot_select_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SOCK_BASE = 32'hFC80_0000,
  parameter int unsigned       SOCK_AW   = 19,
  parameter logic [ADDR_W-1:0] NOR_BASE  = 32'hE000_0000,
  parameter int unsigned       NOR_AW    = 24,
  parameter int unsigned       NOR_BANKS = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hFFF0_0000,
  parameter int unsigned       BOOT_AW   = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       boot_sock,
  input  logic [$clog2(NOR_BANKS)-1:0] boot_bank,
  output logic                       cs_sock,
  output logic [NOR_BANKS-1:0]       cs_nor,
  output logic [NOR_AW-1:0]          dev_off,
  output logic                       dec_err
);
  localparam int unsigned BANK_W = $clog2(NOR_BANKS);
  localparam int unsigned NOR_TW = NOR_AW + BANK_W;

  region_e             region;
  logic [BANK_W-1:0]   nor_idx;
  logic [NOR_BANKS-1:0] bank_hit;
  logic                sock_d, err_d;
  logic [NOR_BANKS-1:0] nor_d;
  logic [NOR_AW-1:0]   off_d;

  always_comb begin
    region = RG_NONE;
    if (req_addr[ADDR_W-1:SOCK_AW] == SOCK_BASE[ADDR_W-1:SOCK_AW])     region = RG_SOCK;
    else if (req_addr[ADDR_W-1:NOR_TW] == NOR_BASE[ADDR_W-1:NOR_TW])   region = RG_NOR;
    else if (req_addr[ADDR_W-1:BOOT_AW] == BOOT_BASE[ADDR_W-1:BOOT_AW]) region = RG_BOOT;
  end

  assign nor_idx = req_addr[NOR_AW +: BANK_W];

  for (genvar g = 0; g < NOR_BANKS; g++) begin : g_bank
    assign bank_hit[g] =
      ((region == RG_NOR) && (nor_idx == BANK_W'(g))) ||
      ((region == RG_BOOT) && !boot_sock && (boot_bank == BANK_W'(g)));
  end

  always_comb begin
    sock_d = 1'b0;
    nor_d  = '0;
    off_d  = '0;
    err_d  = 1'b0;
    if (req_valid) begin
      nor_d = bank_hit;
      unique case (region)
        RG_SOCK: begin
          sock_d = 1'b1;
          off_d  = NOR_AW'(req_addr[SOCK_AW-1:0]);
        end
        RG_NOR:  off_d = req_addr[NOR_AW-1:0];
        RG_BOOT: begin
          sock_d = boot_sock;
          off_d  = boot_sock ? NOR_AW'(req_addr[SOCK_AW-1:0])
                             : NOR_AW'(req_addr[BOOT_AW-1:0]);
        end
        default: err_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_sock <= 1'b0;
      cs_nor  <= '0;
      dev_off <= '0;
      dec_err <= 1'b0;
    end else begin
      cs_sock <= sock_d;
      cs_nor  <= nor_d;
      dev_off <= off_d;
      dec_err <= err_d;
    end
  end

  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_sock, cs_nor, dec_err}));
  a_r7_err_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> $past(req_valid));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(cs_sock || (|cs_nor) || dec_err));
  a_r5_window_sock: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && boot_sock && (req_addr[ADDR_W-1:BOOT_AW] == BOOT_BASE[ADDR_W-1:BOOT_AW]))
      |=> cs_sock);
endmodule

// File: rtl/boot_select.sv
module boot_select
  import boot_select_pkg::*;
#(
  parameter logic [31:0] SOCK_BASE = 32'hFC80_0000,
  parameter int unsigned SOCK_AW   = 19,
  parameter logic [31:0] NOR_BASE  = 32'hE000_0000,
  parameter int unsigned NOR_AW    = 24,
  parameter int unsigned NOR_BANKS = 2,
  parameter logic [31:0] BOOT_BASE = 32'hFFF0_0000,
  parameter int unsigned BOOT_AW   = 20,
  localparam int unsigned BANK_W   = $clog2(NOR_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 jumper_fit,
  input  logic                 redir_en,
  input  logic                 wdog_exp,
  input  logic                 brd_rst,
  input  logic                 sel_wr,
  input  logic [BANK_W-1:0]    sel_bank,
  input  logic                 clr_flag,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  output logic                 cs_sock,
  output logic [NOR_BANKS-1:0] cs_nor,
  output logic [NOR_AW-1:0]    dev_off,
  output logic                 dec_err,
  output logic [7:0]           boot_status
);
  logic              boot_sock;
  logic [BANK_W-1:0] boot_bank;
  logic              redir_flag;

  boot_sel_state #(.BANK_W(BANK_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .jumper_fit (jumper_fit),
    .redir_en   (redir_en),
    .wdog_exp   (wdog_exp),
    .brd_rst    (brd_rst),
    .sel_wr     (sel_wr),
    .sel_bank   (sel_bank),
    .clr_flag   (clr_flag),
    .boot_sock  (boot_sock),
    .boot_bank  (boot_bank),
    .redir_flag (redir_flag)
  );

  boot_addr_decode #(
    .SOCK_BASE (SOCK_BASE), .SOCK_AW (SOCK_AW),
    .NOR_BASE  (NOR_BASE),  .NOR_AW  (NOR_AW), .NOR_BANKS (NOR_BANKS),
    .BOOT_BASE (BOOT_BASE), .BOOT_AW (BOOT_AW)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .boot_sock (boot_sock),
    .boot_bank (boot_bank),
    .cs_sock   (cs_sock),
    .cs_nor    (cs_nor),
    .dev_off   (dev_off),
    .dec_err   (dec_err)
  );

  always_comb begin
    boot_status = '0;
    boot_status[ST_SOCK_BIT] = boot_sock;
    boot_status[ST_FLAG_BIT] = redir_flag;
    boot_status[ST_BANK_BIT] = boot_bank[0];
  end

  a_r10_load_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (brd_rst && !redir_flag) |=> (boot_status[ST_BANK_BIT] == $past(u_state.prim_bank[0])));
endmodule

// File: tb/boot_select_test.sv
module boot_select_test;
  logic        clk = 1'b0;
  logic        rst_n, jumper_fit, redir_en, wdog_exp, brd_rst;
  logic        sel_wr, sel_bank, clr_flag, req_valid;
  logic [31:0] req_addr;
  logic        cs_sock, dec_err;
  logic [1:0]  cs_nor;
  logic [23:0] dev_off;
  logic [7:0]  boot_status;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  int m_sock, m_bank, m_prim, m_flag;
  int e_sock, e_nor, e_off, e_err;

  always #2 clk = ~clk;

  boot_select uut (
    .clk(clk), .rst_n(rst_n), .jumper_fit(jumper_fit), .redir_en(redir_en),
    .wdog_exp(wdog_exp), .brd_rst(brd_rst), .sel_wr(sel_wr), .sel_bank(sel_bank),
    .clr_flag(clr_flag), .req_valid(req_valid), .req_addr(req_addr),
    .cs_sock(cs_sock), .cs_nor(cs_nor), .dev_off(dev_off), .dec_err(dec_err),
    .boot_status(boot_status)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    longint unsigned a;
    int nb;
    a = longint'(req_addr);
    if (!rst_n) begin
      m_sock = jumper_fit; m_bank = 0; m_prim = 0; m_flag = 0;
      e_sock = 0; e_nor = 0; e_off = 0; e_err = 0;
    end else begin
      e_sock = 0; e_nor = 0; e_off = 0; e_err = 0;
      if (req_valid) begin
        if (a >= 64'hFC80_0000 && a < 64'hFC88_0000) begin
          e_sock = 1; e_off = int'(a - 64'hFC80_0000);
        end else if (a >= 64'hE000_0000 && a < 64'hE200_0000) begin
          e_nor = 1 << int'((a - 64'hE000_0000) / (1 << 24));
          e_off = int'((a - 64'hE000_0000) % (1 << 24));
        end else if (a >= 64'hFFF0_0000) begin
          if (m_sock == 1) begin
            e_sock = 1; e_off = int'((a - 64'hFFF0_0000) % (1 << 19));
          end else begin
            e_nor = 1 << m_bank; e_off = int'(a - 64'hFFF0_0000);
          end
        end else e_err = 1;
      end
      nb = (m_prim + m_flag) % 2;
      if (brd_rst) begin m_sock = jumper_fit; m_bank = nb; end
      if (sel_wr) m_prim = sel_bank;
      if (wdog_exp && redir_en) m_flag = 1;
      else if (clr_flag) m_flag = 0;
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "cs_sock", cs_sock, e_sock);
    chk(tag, "cs_nor", cs_nor, e_nor);
    chk(tag, "dev_off", dev_off, e_off);
    chk(tag, "dec_err", dec_err, e_err);
    chk(tag, "boot_status", boot_status, (m_sock << 5) | (m_flag << 1) | m_bank);
  endtask

  task automatic acc(logic [31:0] a, string tag);
    req_valid = 1'b1; req_addr = a;
    step(tag);
    req_valid = 1'b0; req_addr = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; jumper_fit = 1; redir_en = 0; wdog_exp = 0; brd_rst = 0;
    sel_wr = 0; sel_bank = 0; clr_flag = 0; req_valid = 0; req_addr = '0;
    step("R1"); step("R1");
    rst_n = 1;
    step("R1");
    // decode with socket boot
    acc(32'hFC80_0000, "R3");
    acc(32'hFC87_FFFC, "R3");
    acc(32'hFFF0_0010, "R5");
    acc(32'hFFF8_0004, "R5");
    acc(32'hE000_1234, "R4");
    acc(32'hE100_0008, "R4");
    acc(32'hE1FF_FFFE, "R4");
    acc(32'h1000_0000, "R7");
    acc(32'hFC88_0000, "R7");
    acc(32'hE200_0000, "R7");
    step("R7");
    // fall-back flag
    wdog_exp = 1; step("R8"); wdog_exp = 0; step("R8");
    redir_en = 1; wdog_exp = 1; step("R8"); wdog_exp = 0; step("R2");
    clr_flag = 1; wdog_exp = 1; step("R9"); wdog_exp = 0; step("R9");
    step("R9"); clr_flag = 0; step("R9");
    // jumper change only at board reset
    wdog_exp = 1; step("R8"); wdog_exp = 0;
    jumper_fit = 0; step("R11");
    acc(32'hFFF0_0000, "R11");
    brd_rst = 1; step("R10"); brd_rst = 0;
    acc(32'hFFF0_0100, "R6");
    acc(32'hFFFF_FFFE, "R6");
    clr_flag = 1; step("R9"); clr_flag = 0;
    sel_wr = 1; sel_bank = 1; step("R10"); sel_wr = 0; sel_bank = 0;
    brd_rst = 1; step("R10"); brd_rst = 0;
    acc(32'hFFF4_0000, "R6");
    sel_wr = 1; sel_bank = 0; step("R10"); sel_wr = 0;
    brd_rst = 1; step("R10"); brd_rst = 0;
    acc(32'hFFF0_0044, "R6");
    jumper_fit = 1; brd_rst = 1; step("R11"); brd_rst = 0;
    acc(32'hFFFA_BCDE, "R5");
    // random stream
    for (int i = 0; i < 2000; i++) begin
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: req_addr = 32'hFC80_0000 | ($urandom & 32'h0007_FFFF);
        1: req_addr = 32'hE000_0000 | ($urandom & 32'h01FF_FFFF);
        2, 3: req_addr = 32'hFFF0_0000 | ($urandom & 32'h000F_FFFF);
        default: req_addr = $urandom;
      endcase
      req_valid  = ($urandom_range(0, 3) != 0);
      jumper_fit = ($urandom_range(0, 7) != 0) ? jumper_fit : ~jumper_fit;
      redir_en   = ($urandom_range(0, 9) != 0) ? redir_en : ~redir_en;
      wdog_exp   = ($urandom_range(0, 15) == 0);
      clr_flag   = ($urandom_range(0, 15) == 0);
      brd_rst    = ($urandom_range(0, 19) == 0);
      sel_wr     = ($urandom_range(0, 15) == 0);
      sel_bank   = 1'($urandom);
      step("R7");
    end
    req_valid = 0; wdog_exp = 0; clr_flag = 0; brd_rst = 0; sel_wr = 0;
    step("R7");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule